// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers a reset request and a set of interrupt request lines (sixteen by default). It latches each request as a pending flag and picks one winner by fixed priority. It then presents the program-memory vector address of that winner to the processor core, together with a valid flag. The reset request owns vector address 0 and cannot be masked. Interrupt line `i` (bit `i` of `irq_req`) owns vector address `i+1`. The lower address always wins.

Software controls two things through a small write port: a per-line enable mask and a global interrupt-enable bit. A line can win only when its own enable bit and the global bit are both set. When the core takes a vector, it pulses `ack`. That clears the pending flag of the presented vector. If the vector is not the reset vector, `ack` also clears the global enable, which blocks nesting. A `reti` strobe sets the global enable again when the handler returns.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After `rst_n` is released, `vec_valid` is 0 and `vec_addr` is 0. All line enables and the global enable are 0.
- R2: A one-cycle pulse on `irq_req[i]` or `rst_req` is latched as pending. If that source is eligible, `vec_valid` is 1 in the cycle after the clock edge that samples the pulse.
- R3: A pending reset request presents `vec_addr` = 0. It does so whatever the enables are, and ahead of every pending interrupt.
- R4: Interrupt line `i` presents `vec_addr` = `i+1`. Among eligible lines, the lowest index wins.
- R5: Line `i` is eligible only when it is pending, its enable bit is 1 and the global enable is 1. The enable bit is set by a write with `cfg_sel`=0, which loads `cfg_wdata` as the mask. The global enable is set by a write with `cfg_sel`=1, which loads `cfg_wdata[0]`.
- R6: A pending flag stays set while its line is disabled. The line is presented once it is enabled.
- R7: `ack` while `vec_valid` is 1 clears the pending flag of the presented vector. An `ack` while `vec_valid` is 0 has no effect.
- R8: Acknowledging a non-zero vector clears the global enable. Acknowledging vector 0 leaves it unchanged. A `reti` pulse sets it to 1. When `ack` and `reti` arrive in the same cycle, the clear wins.
- R9: While `vec_valid` is 0, `vec_addr` holds the last address presented with `vec_valid` = 1. It is 0 if no address has been presented since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Reset request pulse (pin, power-on or watchdog) |
| irq_req | input | NUM_SRC | Interrupt request pulses, one per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: enable mask, 1: global enable |
| cfg_wdata | input | NUM_SRC | Configuration write data |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | A vector is being presented |
| vec_addr | output | VEC_W | Vector address of the winner |

## Verification
All state is held in registers, and both outputs are decoded from that state without further delay. A request, configuration write, `ack` or `reti` that is sampled at one rising edge is therefore visible on `vec_valid` and `vec_addr` right after that edge. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then reads the outputs at the next falling edge. Tests that involve several steps advance one edge per step and check after each step that matters.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic {
        CFG_MASK   = 1'b0,
        CFG_GLOBAL = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_d, pend_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb pend_d[g] = (pend_q[g] & ~clr[g]) | set[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R7
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
    // R2
    set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [NUM_SRC-1:0] cfg_wdata,
    input  logic               ack,
    input  logic               reti,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               gie;
        logic               rst_pend;
        logic [VEC_W-1:0]   hold;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [NUM_SRC-1:0] pend, eligible, clr;
    logic               found, take, take_irq;
    logic [IW-1:0]      idx;
    logic [VEC_W-1:0]   win_addr;

    irq_pend_bank #(.N(NUM_SRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (irq_req),
        .clr  (clr),
        .pend (pend)
    );

    assign eligible = pend & st_q.en & {NUM_SRC{st_q.gie}};

    irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc (
        .req  (eligible),
        .found(found),
        .idx  (idx)
    );

    always_comb begin
        vec_valid = st_q.rst_pend | found;
        win_addr  = st_q.rst_pend ? '0 : VEC_W'(idx) + VEC_W'(1);
        vec_addr  = vec_valid ? win_addr : st_q.hold;
        take      = ack & vec_valid;
        take_irq  = take & ~st_q.rst_pend;
        clr       = '0;
        if (take_irq) clr[idx] = 1'b1;

        st_d = st_q;
        if (cfg_we && cfg_sel == CFG_MASK)   st_d.en  = cfg_wdata;
        if (cfg_we && cfg_sel == CFG_GLOBAL) st_d.gie = cfg_wdata[0];
        if (reti)                            st_d.gie = 1'b1;
        if (take_irq)                        st_d.gie = 1'b0;
        if (take && st_q.rst_pend)           st_d.rst_pend = 1'b0;
        if (rst_req)                         st_d.rst_pend = 1'b1;
        if (vec_valid)                       st_d.hold = win_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (vec_valid && vec_addr == '0));
    // R5
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_addr != '0) |-> (st_q.gie && st_q.en[vec_addr - VEC_W'(1)]
                                          && pend[vec_addr - VEC_W'(1)]));
    // R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_addr) <= NUM_SRC));
    // R8
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec_valid && vec_addr != '0 && !rst_req) |=> (!st_q.gie && vec_addr != '0 || !vec_valid || vec_addr == '0));
    // R8
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec_valid && vec_addr != '0) |=> !st_q.gie);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> $stable(vec_addr));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam int N  = 16;
    localparam int VW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_req = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [N-1:0]  cfg_wdata = '0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          vec_valid;
    logic [VW-1:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_req(irq_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ack(ack), .reti(reti), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    // row: request pulse, enable mask, global bit, expected valid, expected address
    typedef struct packed {
        logic [N-1:0]  irq;
        logic [N-1:0]  en;
        logic          g;
        logic          ev;
        logic [VW-1:0] ea;
    } row_t;

    localparam int ROWS = 8;
    localparam row_t TBL [ROWS] = '{
        '{16'h0001, 16'hFFFF, 1'b1, 1'b1, 5'd1},
        '{16'h8001, 16'hFFFF, 1'b1, 1'b1, 5'd1},
        '{16'h8000, 16'hFFFF, 1'b1, 1'b1, 5'd16},
        '{16'h00F0, 16'h00C0, 1'b1, 1'b1, 5'd7},
        '{16'hFFFF, 16'h0000, 1'b1, 1'b0, 5'd0},
        '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 5'd0},
        '{16'h0100, 16'h0100, 1'b1, 1'b1, 5'd9},
        '{16'h0300, 16'h0200, 1'b1, 1'b1, 5'd10}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic ev, input logic [VW-1:0] ea);
        checks++;
        if (vec_valid !== ev || (vec_addr !== ea)) begin
            errors++;
            $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d",
                     req, vec_valid, vec_addr, ev, ea);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic cfg(input logic sel, input logic [N-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_irq(input logic [N-1:0] r);
        irq_req = r;
        step();
        irq_req = '0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        do_reset();
        chk("R1 reset state", 1'b0, 5'd0);

        // R4 R5 table walk
        for (int i = 0; i < ROWS; i++) begin
            do_reset();
            cfg(1'b0, TBL[i].en);
            cfg(1'b1, {{(N-1){1'b0}}, TBL[i].g});
            pulse_irq(TBL[i].irq);
            chk($sformatf("R4/R5 row %0d", i), TBL[i].ev, TBL[i].ea);
        end

        // R3: reset request unmasked and ahead of interrupts
        do_reset();
        rst_req = 1'b1; step(); rst_req = 1'b0;
        chk("R3 reset vector while disabled", 1'b1, 5'd0);
        cfg(1'b0, '1);
        cfg(1'b1, 16'h1);
        pulse_irq(16'h0004);
        chk("R3 reset beats interrupt", 1'b1, 5'd0);
        pulse_ack();
        chk("R8 reset ack keeps global enable", 1'b1, 5'd3);

        // R2 R7 R8 R9: ack sequence
        do_reset();
        cfg(1'b0, '1);
        cfg(1'b1, 16'h1);
        irq_req = 16'h0012; step(); irq_req = '0;
        chk("R2 next-cycle valid", 1'b1, 5'd2);
        pulse_ack();
        chk("R8 ack clears global, R9 hold", 1'b0, 5'd2);
        step();
        chk("R9 hold over idle cycle", 1'b0, 5'd2);
        reti = 1'b1; step(); reti = 1'b0;
        chk("R8 reti restores, R7 line 1 cleared", 1'b1, 5'd5);
        ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
        chk("R8 ack beats reti", 1'b0, 5'd5);
        reti = 1'b1; step(); reti = 1'b0;
        chk("R7 all serviced", 1'b0, 5'd5);

        // R6 R7: pending survives disable; ack with valid low ignored
        do_reset();
        cfg(1'b1, 16'h1);
        pulse_irq(16'h0008);
        chk("R6 disabled pending not shown", 1'b0, 5'd0);
        pulse_ack();
        chk("R7 ack idle no effect", 1'b0, 5'd0);
        cfg(1'b0, 16'h0008);
        chk("R6 shown once enabled", 1'b1, 5'd4);
        cfg(1'b0, 16'h0000);
        chk("R9 disabled again holds addr", 1'b0, 5'd4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule